// File: doc/BRIEF.md
# Banked ROM Mapper with Split-Port RAM

This block decodes accesses from an 8-bit CPU into a 4 KB cartridge window. Behind that window sit 16 KB of ROM, arranged as four 4 KB banks with exactly one bank visible at a time, and a 128-byte RAM. The RAM is reached through two separate 128-byte windows. Writes go to the low window and reads come from the window just above it. There is no write-enable pin for the RAM: the address alone decides whether a write is stored.

Four fixed offsets near the top of the window act as bank-select hotspots. Touching one of them with a read or a write switches the visible bank. The bank is a small state machine with states BANK0, BANK1, BANK2 and BANK3. From any state, a hotspot access moves it to the bank that hotspot names (offset 0xFF6 goes to BANK0, 0xFF7 to BANK1, 0xFF8 to BANK2, 0xFF9 to BANK3). Every other cycle holds the current state. Reset enters BANK0.

The ROM array is held outside the block. The block presents a 14-bit ROM byte address, made of the bank followed by the offset, and takes the byte back in the same cycle. Read data is registered on the strobe edge. A write that lands on the read-only RAM window raises a one-cycle violation flag.

Top module: `bank_rom_mapper`

## Requirements
- R1: After reset, `bank` is 0, `rdata` is 0x00 and `ram_wr_viol` is 0.
- R2: A selected access (cs=1, with rd=1 or wr=1) to offset 0xFF6, 0xFF7, 0xFF8 or 0xFF9 sets `bank` to 0, 1, 2 or 3 respectively after that clock edge. This holds whether the access is a read or a write.
- R3: A selected read of an offset at or above 0x100 loads `rdata`, after the edge, with the ROM byte at address bank*4096 + offset. Here `rom_addr` = {bank[1:0], offset[11:0]}.
- R4: A selected read of a hotspot returns the byte from the newly selected bank at that offset, in the same cycle as the bank change.
- R5: A selected write to offsets 0x000 through 0x07F stores `wdata` at RAM index offset[6:0].
- R6: A selected read of offsets 0x080 through 0x0FF returns the RAM byte at index offset[6:0] on `rdata` after the edge.
- R7: A selected write to offsets 0x080 through 0x0FF leaves the RAM unchanged. It drives `ram_wr_viol` high for exactly the one cycle after that edge.
- R8: A selected write to a hotspot, or to any other offset at or above 0x100, stores nothing in the RAM and does not raise `ram_wr_viol`.
- R9: With cs=0, no access has any effect: `bank`, the RAM and `rdata` are unchanged and `ram_wr_viol` stays 0.
- R10: `rdata` changes only on the edge of a selected read. When rd and wr are both high in the same cycle, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Cartridge select (CPU address bit 12) |
| addr | input | 12 | Offset inside the cartridge window |
| rd | input | 1 | Single-cycle read strobe |
| wr | input | 1 | Single-cycle write strobe |
| wdata | input | 8 | Write data byte |
| rom_data | input | 8 | ROM byte at `rom_addr`, combinational |
| rom_addr | output | 14 | ROM byte address {bank, offset} |
| rdata | output | 8 | Registered read data |
| bank | output | 2 | Current bank number |
| ram_wr_viol | output | 1 | One-cycle pulse after a write to the RAM read window |

## Verification
A read of a hotspot changes the bank and returns data in one cycle, so the ROM address used for that read must already carry the new bank. The bench provokes this by reading each hotspot from a different starting bank. It then compares `rdata` against the bench's own ROM function evaluated at the new bank, which differs from the old bank's byte at every offset. The second same-cycle pairing is a write to the read window, which must raise the flag and leave the RAM intact. This is judged by reading that RAM index back through the read window afterwards.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int OFF_W   = 12;
    localparam int BANK_W  = 2;
    localparam int RAM_AW  = 7;
    localparam int DATA_W  = 8;

    typedef enum logic [BANK_W-1:0] {
        BANK0 = 2'd0,
        BANK1 = 2'd1,
        BANK2 = 2'd2,
        BANK3 = 2'd3
    } bank_e;

    typedef enum logic [1:0] {
        K_RAM_WR  = 2'd0,
        K_RAM_RD  = 2'd1,
        K_HOT     = 2'd2,
        K_ROM     = 2'd3
    } region_e;

endpackage

// File: rtl/mapper_decode.sv
module mapper_decode
    import mapper_pkg::*;
#(
    parameter int             AW       = OFF_W,
    parameter int             RAW      = RAM_AW,
    parameter int             BW       = BANK_W,
    parameter logic [AW-1:0]  HOT_BASE = 12'hFF6
) (
    input  logic [AW-1:0] offset,
    output region_e       region,
    output logic [BW-1:0] hot_sel
);
    localparam int            NBANK    = 1 << BW;
    localparam logic [AW:0]   RAM_SPAN = (AW+1)'(1) << RAW;
    localparam logic [AW:0]   HOT_END  = {1'b0, HOT_BASE} + (AW+1)'(NBANK);

    logic [AW:0] off_ext;
    logic [AW:0] hot_rel;

    always_comb begin
        off_ext = {1'b0, offset};
        hot_rel = off_ext - {1'b0, HOT_BASE};
        hot_sel = hot_rel[BW-1:0];
        if (off_ext < RAM_SPAN)
            region = K_RAM_WR;
        else if (off_ext < (RAM_SPAN << 1))
            region = K_RAM_RD;
        else if (off_ext >= {1'b0, HOT_BASE} && off_ext < HOT_END)
            region = K_HOT;
        else
            region = K_ROM;
    end

endmodule

// File: rtl/mapper_bank_fsm.sv
module mapper_bank_fsm
    import mapper_pkg::*;
#(
    parameter int BW = BANK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hot_hit,
    input  logic [BW-1:0] hot_sel,
    output bank_e         state,
    output bank_e         state_nx
);
    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= BANK0;
        else
            state <= state_nx;
    end

    // next state: any hotspot access jumps straight to its named bank
    always_comb begin
        state_nx = state;
        if (hot_hit) begin
            unique case (hot_sel)
                2'd0:    state_nx = BANK0;
                2'd1:    state_nx = BANK1;
                2'd2:    state_nx = BANK2;
                default: state_nx = BANK3;
            endcase
        end
    end

    a_r2_hot_jump: assert property (@(posedge clk) disable iff (!rst_n)
        hot_hit |=> (state == bank_e'($past(hot_sel))));

    a_r9_hold_bank: assert property (@(posedge clk) disable iff (!rst_n)
        !hot_hit |=> $stable(state));

endmodule

// File: rtl/mapper_ram.sv
module mapper_ram
    import mapper_pkg::*;
#(
    parameter int RAW = RAM_AW,
    parameter int DW  = DATA_W
) (
    input  logic           clk,
    input  logic           we,
    input  logic [RAW-1:0] idx,
    input  logic [DW-1:0]  din,
    output logic [DW-1:0]  dout
);
    localparam int DEPTH = 1 << RAW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[idx] <= din;
    end

    assign dout = cells[idx];

endmodule

// File: rtl/bank_rom_mapper.sv
module bank_rom_mapper
    import mapper_pkg::*;
#(
    parameter int AW  = OFF_W,
    parameter int BW  = BANK_W,
    parameter int RAW = RAM_AW,
    parameter int DW  = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic [AW-1:0]    addr,
    input  logic             rd,
    input  logic             wr,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    rom_data,
    output logic [BW+AW-1:0] rom_addr,
    output logic [DW-1:0]    rdata,
    output logic [BW-1:0]    bank,
    output logic             ram_wr_viol
);
    region_e       region;
    logic [BW-1:0] hot_sel;
    bank_e         st, st_nx;
    logic          is_wr, is_rd, hot_hit, ram_we, viol_nx;
    logic [DW-1:0] ram_q;

    mapper_decode #(.AW(AW), .RAW(RAW), .BW(BW)) u_dec (
        .offset (addr),
        .region (region),
        .hot_sel(hot_sel)
    );

    // a write wins when both strobes are high
    assign is_wr   = cs && wr;
    assign is_rd   = cs && rd && !wr;
    assign hot_hit = (is_wr || is_rd) && (region == K_HOT);
    assign ram_we  = is_wr && (region == K_RAM_WR);
    assign viol_nx = is_wr && (region == K_RAM_RD);

    mapper_bank_fsm #(.BW(BW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hot_hit (hot_hit),
        .hot_sel (hot_sel),
        .state   (st),
        .state_nx(st_nx)
    );

    mapper_ram #(.RAW(RAW), .DW(DW)) u_ram (
        .clk (clk),
        .we  (ram_we),
        .idx (addr[RAW-1:0]),
        .din (wdata),
        .dout(ram_q)
    );

    // the ROM address uses the next bank so a hotspot read sees the new bank
    assign rom_addr = {st_nx, addr};
    assign bank     = st;

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata       <= '0;
            ram_wr_viol <= 1'b0;
        end else begin
            ram_wr_viol <= viol_nx;
            if (is_rd) begin
                unique case (region)
                    K_RAM_WR, K_RAM_RD: rdata <= ram_q;
                    default:            rdata <= rom_data;
                endcase
            end
        end
    end

    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd && !wr) |=> $stable(rdata));

    a_r7_viol_source: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_viol |-> $past(cs && wr && addr[AW-1:RAW] == 1));

    a_r8_no_viol_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr >= AW'(256)) |=> !ram_wr_viol);

    a_r9_no_viol_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !ram_wr_viol);

endmodule

// File: tb/sim_bank_rom_mapper.sv
`timescale 1ns/1ps
module sim_bank_rom_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0;
    logic [11:0] addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rom_data;
    logic [13:0] rom_addr;
    logic [7:0]  rdata;
    logic [1:0]  bank;
    logic        ram_wr_viol;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bank_rom_mapper u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rom_data(rom_data), .rom_addr(rom_addr),
        .rdata(rdata), .bank(bank), .ram_wr_viol(ram_wr_viol)
    );

    function automatic logic [7:0] romf(input logic [13:0] a);
        return (a[7:0] + 8'(a[13:8]) * 8'd37) ^ 8'h5A;
    endfunction

    always_comb rom_data = romf(rom_addr);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // one bus cycle: drive at negedge, strobe over a rising edge, sample at next negedge
    task automatic bus(input logic c, input logic [11:0] a, input logic r,
                       input logic w, input logic [7:0] d);
        @(negedge clk);
        cs = c; addr = a; rd = r; wr = w; wdata = d;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0; wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 bank", 32'(bank), 0);
        chk("R1 rdata", 32'(rdata), 0);
        chk("R1 viol", 32'(ram_wr_viol), 0);
    endtask

    task automatic t_hot_write();
        bus(1, 12'hFF8, 0, 1, 8'hAA); chk("R2 wr FF8", 32'(bank), 2);
        bus(1, 12'hFF7, 0, 1, 8'h00); chk("R2 wr FF7", 32'(bank), 1);
        bus(1, 12'hFF9, 1, 0, 8'h00); chk("R2 rd FF9", 32'(bank), 3);
        bus(1, 12'hFF6, 1, 0, 8'h00); chk("R2 rd FF6", 32'(bank), 0);
        bus(1, 12'hFF5, 1, 0, 8'h00); chk("R2 FF5 not hot", 32'(bank), 0);
        bus(1, 12'hFFA, 0, 1, 8'h00); chk("R2 FFA not hot", 32'(bank), 0);
    endtask

    task automatic t_rom_read();
        for (int b = 0; b < 4; b++) begin
            bus(1, 12'(12'hFF6 + b), 0, 1, 8'h00);
            bus(1, 12'h100, 1, 0, 8'h00);
            chk("R3 rom 100", 32'(rdata), 32'(romf({2'(b), 12'h100})));
            bus(1, 12'hABC, 1, 0, 8'h00);
            chk("R3 rom ABC", 32'(rdata), 32'(romf({2'(b), 12'hABC})));
            bus(1, 12'hFFF, 1, 0, 8'h00);
            chk("R3 rom FFF", 32'(rdata), 32'(romf({2'(b), 12'hFFF})));
        end
    endtask

    task automatic t_hot_read();
        bus(1, 12'hFF6, 0, 1, 8'h00);
        bus(1, 12'hFF9, 1, 0, 8'h00);
        chk("R4 bank", 32'(bank), 3);
        chk("R4 data FF9", 32'(rdata), 32'(romf({2'd3, 12'hFF9})));
        bus(1, 12'hFF7, 1, 0, 8'h00);
        chk("R4 data FF7", 32'(rdata), 32'(romf({2'd1, 12'hFF7})));
        bus(1, 12'hFF8, 1, 0, 8'h00);
        chk("R4 data FF8", 32'(rdata), 32'(romf({2'd2, 12'hFF8})));
    endtask

    task automatic t_ram();
        bus(1, 12'h000, 0, 1, 8'h11);
        bus(1, 12'h07F, 0, 1, 8'h7E);
        bus(1, 12'h035, 0, 1, 8'hC3);
        bus(1, 12'h080, 1, 0, 8'h00); chk("R6 idx0", 32'(rdata), 32'h11);
        bus(1, 12'h0FF, 1, 0, 8'h00); chk("R6 idx7F", 32'(rdata), 32'h7E);
        bus(1, 12'h0B5, 1, 0, 8'h00); chk("R5 idx35", 32'(rdata), 32'hC3);
    endtask

    task automatic t_viol();
        bus(1, 12'h0B5, 0, 1, 8'h99);
        chk("R7 pulse", 32'(ram_wr_viol), 1);
        @(negedge clk);
        chk("R7 one cycle", 32'(ram_wr_viol), 0);
        bus(1, 12'h0B5, 1, 0, 8'h00);
        chk("R7 ram kept", 32'(rdata), 32'hC3);
    endtask

    task automatic t_ignore();
        bus(1, 12'hFF8, 0, 1, 8'h35);
        chk("R8 hot wr viol", 32'(ram_wr_viol), 0);
        bus(1, 12'h135, 0, 1, 8'h44);
        chk("R8 rom wr viol", 32'(ram_wr_viol), 0);
        chk("R8 bank", 32'(bank), 2);
        bus(1, 12'h0B5, 1, 0, 8'h00);
        chk("R8 ram kept", 32'(rdata), 32'hC3);
        bus(1, 12'h0B5, 1, 1, 8'h00);
        chk("R10 rd+wr no load", 32'(rdata), 32'hC3);
        chk("R10 rd+wr viol", 32'(ram_wr_viol), 1);
    endtask

    task automatic t_cs_low();
        bus(0, 12'hFF6, 1, 0, 8'h00);
        chk("R9 bank", 32'(bank), 2);
        chk("R9 rdata", 32'(rdata), 32'hC3);
        bus(0, 12'h035, 0, 1, 8'h01);
        bus(0, 12'h0B5, 0, 1, 8'h02);
        chk("R9 viol", 32'(ram_wr_viol), 0);
        bus(1, 12'h0B5, 1, 0, 8'h00);
        chk("R9 ram kept", 32'(rdata), 32'hC3);
        @(negedge clk);
        chk("R10 hold", 32'(rdata), 32'hC3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hot_write();
        t_rom_read();
        t_hot_read();
        t_ram();
        t_viol();
        t_ignore();
        t_cs_low();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule